// File: doc/BRIEF.md
# Frame-Aware Stream Input Multiplexer

This block routes one of several AXI4-Stream inputs to a single AXI4-Stream output. A `select` input picks the source. An `enable` input gates whether a new transfer may begin. In the default framed mode a frame is never split across sources. A change of `select` made while a frame is in flight waits until that frame's `tlast` beat has been accepted. The next frame then comes from the newly chosen input. A parameter turns framing off. In that mode `tlast` is carried through but plays no part in switching, so the route follows `select` at any beat.

The output side is a register slice with a single skid entry. Because of it, the `tready` lines toward the inputs come straight from registers and the block can still move one beat per clock. Frames that follow each other leave no idle cycle on the output. Each of the keep, id, destination and user sidebands has its own enable parameter. When a sideband is disabled, its output is a constant. Select codes beyond the last input route nothing.

Top module: `smux_stream_mux`

## Requirements
- R1: In framed mode, a `select` change during a frame takes effect only after that frame's `tlast` beat is accepted. Every beat of a frame leaves from one input, and the first beat of the next frame comes from the newly selected input.
- R2: At most one `s_axis_tready` bit is high in any cycle, and only the bit of the granted input can be high.
- R3: While `m_axis_tvalid` is high and `m_axis_tready` is low, `m_axis_tvalid` stays high and every output field stays unchanged on the next cycle.
- R4: When the consumer is always ready and the selected inputs present data continuously, the output carries one beat per cycle across frame ends and source changes, with no cycle of `m_axis_tvalid` low.
- R5: With framing disabled, `tlast` is forwarded unchanged but ignored for switching, and a `select` change moves the route within three cycles even in the middle of a frame.
- R6: A disabled sideband drives a constant on the output: `m_axis_tkeep` all ones, and `m_axis_tid`, `m_axis_tdest` and `m_axis_tuser` all zeros.
- R7: While `enable` is low between frames, no input sees `tready` and no frame starts. A frame already started when `enable` falls runs to its `tlast` beat.
- R8: While `rst` is high, `m_axis_tvalid` and every `s_axis_tready` bit are low.
- R9: A `select` value equal to or above the number of inputs grants no input: all `tready` bits stay low and no output beat appears.
- R10: Every accepted input beat leaves the output exactly once, in acceptance order, with data, keep, id, user and `tlast` intact. The input's bit packing is `{src[1:0], seq[5:0]}` in data in the bench.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows a new frame (or beat when unframed) to start |
| select | input | SEL_W | Index of the input to route |
| s_axis_tdata | input | N_SRC*DATA_W | Input data, input i in slice i |
| s_axis_tkeep | input | N_SRC*KEEP_W | Input byte qualifiers |
| s_axis_tvalid | input | N_SRC | Input valid per source |
| s_axis_tready | output | N_SRC | Input ready per source (registered) |
| s_axis_tlast | input | N_SRC | Input end-of-frame marker |
| s_axis_tid | input | N_SRC*ID_W | Input stream id |
| s_axis_tdest | input | N_SRC*DEST_W | Input routing tag |
| s_axis_tuser | input | N_SRC*USER_W | Input user sideband |
| m_axis_tdata | output | DATA_W | Output data |
| m_axis_tkeep | output | KEEP_W | Output byte qualifiers |
| m_axis_tvalid | output | 1 | Output valid |
| m_axis_tready | input | 1 | Output ready from consumer |
| m_axis_tlast | output | 1 | Output end-of-frame marker |
| m_axis_tid | output | ID_W | Output stream id |
| m_axis_tdest | output | DEST_W | Output routing tag |
| m_axis_tuser | output | USER_W | Output user sideband |

## Verification
The first pattern is a plain frame from one source. It is followed by a frame during which `select` is moved to a second source that already holds valid data. This second pattern separates a mux that defers the switch from one that splits the frame or replays a stale beat. Two chained frames from different sources with an always-ready consumer expose any bubble after `tlast`. A long run under random backpressure shows whether the skid entry loses, duplicates or alters beats. Further patterns pin the gating behaviour and the unframed variant. These are: an out-of-range select, `enable` dropped both before and inside a frame, and a second instance with framing off, switched mid-frame.

// File: rtl/smux_pkg.sv
`timescale 1ns/1ps
package smux_pkg;

    localparam int SMUX_MAX_SRC = 32;

    typedef enum logic {
        FS_GAP  = 1'b0,
        FS_BODY = 1'b1
    } frame_state_e;

    function automatic logic [SMUX_MAX_SRC-1:0] decode_sel(
        input int unsigned sel,
        input logic        en,
        input int unsigned n_src
    );
        logic [SMUX_MAX_SRC-1:0] r;
        r = '0;
        if (en && sel < n_src && sel < SMUX_MAX_SRC) r[sel] = 1'b1;
        return r;
    endfunction

    function automatic int beat_bits(
        input int dw, input int kw, input int iw, input int tw, input int uw
    );
        return dw + kw + iw + tw + uw + 1;
    endfunction

endpackage

// File: rtl/smux_sel_ctrl.sv
`timescale 1ns/1ps
module smux_sel_ctrl
    import smux_pkg::*;
#(
    parameter int N_SRC  = 3,
    parameter int SEL_W  = 2,
    parameter bit FRAMED = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [SEL_W-1:0] select,
    input  logic             fire,
    input  logic             fire_last,
    output logic [N_SRC-1:0] grant
);

    frame_state_e     st_q, st_d;
    logic [N_SRC-1:0] grant_q, grant_d, want;
    logic [SMUX_MAX_SRC-1:0] want_full;

    assign want_full = decode_sel(int'(select), enable, N_SRC);
    assign want      = want_full[N_SRC-1:0];

    always_comb begin
        st_d = st_q;
        if (FRAMED && fire) st_d = fire_last ? FS_GAP : FS_BODY;
        grant_d = (st_d == FS_GAP) ? want : grant_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= FS_GAP;
            grant_q <= '0;
        end else begin
            st_q    <= st_d;
            grant_q <= grant_d;
        end
    end

    assign grant = grant_q;

    // R1: inside a frame the route cannot move until tlast is accepted
    a_r1_hold_route: assert property (@(posedge clk) disable iff (rst)
        (st_q == FS_BODY && !(fire && fire_last)) |=> $stable(grant_q));

    // R9: out-of-range select grants nothing once at a boundary
    a_r9_no_grant: assert property (@(posedge clk) disable iff (rst)
        (st_q == FS_GAP && !fire && int'(select) >= N_SRC) |=> (grant_q == '0));

    // R7: enable low at a boundary starts nothing
    a_r7_gate: assert property (@(posedge clk) disable iff (rst)
        (st_q == FS_GAP && !fire && !enable) |=> (grant_q == '0));

endmodule

// File: rtl/smux_gather.sv
`timescale 1ns/1ps
module smux_gather #(
    parameter int N_SRC  = 3,
    parameter int BEAT_W = 16
) (
    input  logic [N_SRC-1:0]        grant,
    input  logic [N_SRC-1:0]        valid_in,
    input  logic [N_SRC*BEAT_W-1:0] beats_in,
    output logic                    valid_out,
    output logic [BEAT_W-1:0]       beat_out
);

    always_comb begin
        beat_out  = '0;
        valid_out = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (grant[i]) begin
                beat_out  = beat_out | beats_in[i*BEAT_W +: BEAT_W];
                valid_out = valid_out | valid_in[i];
            end
        end
    end

endmodule

// File: rtl/smux_skid.sv
`timescale 1ns/1ps
module smux_skid #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_beat,
    output logic         in_ready,
    output logic         out_valid,
    output logic [W-1:0] out_beat,
    input  logic         out_ready
);

    logic         out_valid_q, skid_valid_q, in_ready_q;
    logic [W-1:0] out_beat_q, skid_beat_q;
    logic         stall, in_fire, skid_d;

    assign stall   = out_valid_q & ~out_ready;
    assign in_fire = in_valid & in_ready_q;
    assign skid_d  = stall ? (skid_valid_q | in_fire) : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_q  <= 1'b0;
            skid_valid_q <= 1'b0;
            in_ready_q   <= 1'b0;
            out_beat_q   <= '0;
            skid_beat_q  <= '0;
        end else begin
            skid_valid_q <= skid_d;
            in_ready_q   <= ~skid_d;
            if (!stall) begin
                out_valid_q <= skid_valid_q | in_fire;
                out_beat_q  <= skid_valid_q ? skid_beat_q : in_beat;
            end
            if (stall && in_fire) skid_beat_q <= in_beat;
        end
    end

    assign in_ready  = in_ready_q;
    assign out_valid = out_valid_q;
    assign out_beat  = out_beat_q;

    // R3: a stalled output beat is held intact
    a_r3_hold_beat: assert property (@(posedge clk) disable iff (rst)
        stall |=> (out_valid_q && $stable(out_beat_q)));

    // R4: a beat taken while the output drains is shown on the next cycle
    a_r4_no_bubble: assert property (@(posedge clk) disable iff (rst)
        (in_fire && !stall) |=> out_valid_q);

    // R8: reset leaves both sides idle
    a_r8_reset_idle: assert property (@(posedge clk)
        rst |=> (!out_valid_q && !in_ready_q));

endmodule

// File: rtl/smux_stream_mux.sv
`timescale 1ns/1ps
module smux_stream_mux
    import smux_pkg::*;
#(
    parameter int N_SRC   = 3,
    parameter int DATA_W  = 8,
    parameter bit KEEP_EN = 1'b1,
    parameter int KEEP_W  = (DATA_W + 7) / 8,
    parameter bit ID_EN   = 1'b1,
    parameter int ID_W    = 2,
    parameter bit DEST_EN = 1'b0,
    parameter int DEST_W  = 2,
    parameter bit USER_EN = 1'b1,
    parameter int USER_W  = 1,
    parameter bit FRAMED  = 1'b1,
    parameter int SEL_W   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    enable,
    input  logic [SEL_W-1:0]        select,
    input  logic [N_SRC*DATA_W-1:0] s_axis_tdata,
    input  logic [N_SRC*KEEP_W-1:0] s_axis_tkeep,
    input  logic [N_SRC-1:0]        s_axis_tvalid,
    output logic [N_SRC-1:0]        s_axis_tready,
    input  logic [N_SRC-1:0]        s_axis_tlast,
    input  logic [N_SRC*ID_W-1:0]   s_axis_tid,
    input  logic [N_SRC*DEST_W-1:0] s_axis_tdest,
    input  logic [N_SRC*USER_W-1:0] s_axis_tuser,
    output logic [DATA_W-1:0]       m_axis_tdata,
    output logic [KEEP_W-1:0]       m_axis_tkeep,
    output logic                    m_axis_tvalid,
    input  logic                    m_axis_tready,
    output logic                    m_axis_tlast,
    output logic [ID_W-1:0]         m_axis_tid,
    output logic [DEST_W-1:0]       m_axis_tdest,
    output logic [USER_W-1:0]       m_axis_tuser
);

    localparam int OFS_KEEP = DATA_W;
    localparam int OFS_ID   = OFS_KEEP + KEEP_W;
    localparam int OFS_DEST = OFS_ID + ID_W;
    localparam int OFS_USER = OFS_DEST + DEST_W;
    localparam int OFS_LAST = OFS_USER + USER_W;
    localparam int BEAT_W   = beat_bits(DATA_W, KEEP_W, ID_W, DEST_W, USER_W);

    logic [N_SRC*BEAT_W-1:0] beats;
    logic [N_SRC-1:0]        grant;
    logic [BEAT_W-1:0]       mux_beat, out_beat;
    logic                    mux_valid, slice_ready, fire;

    for (genvar i = 0; i < N_SRC; i++) begin : g_pack
        assign beats[i*BEAT_W +: BEAT_W] = {
            s_axis_tlast[i],
            s_axis_tuser[i*USER_W +: USER_W],
            s_axis_tdest[i*DEST_W +: DEST_W],
            s_axis_tid[i*ID_W +: ID_W],
            s_axis_tkeep[i*KEEP_W +: KEEP_W],
            s_axis_tdata[i*DATA_W +: DATA_W]
        };
    end

    smux_sel_ctrl #(
        .N_SRC (N_SRC),
        .SEL_W (SEL_W),
        .FRAMED(FRAMED)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .select   (select),
        .fire     (fire),
        .fire_last(mux_beat[OFS_LAST]),
        .grant    (grant)
    );

    smux_gather #(
        .N_SRC (N_SRC),
        .BEAT_W(BEAT_W)
    ) u_gather (
        .grant    (grant),
        .valid_in (s_axis_tvalid),
        .beats_in (beats),
        .valid_out(mux_valid),
        .beat_out (mux_beat)
    );

    smux_skid #(
        .W(BEAT_W)
    ) u_slice (
        .clk      (clk),
        .rst      (rst),
        .in_valid (mux_valid),
        .in_beat  (mux_beat),
        .in_ready (slice_ready),
        .out_valid(m_axis_tvalid),
        .out_beat (out_beat),
        .out_ready(m_axis_tready)
    );

    assign fire          = mux_valid & slice_ready;
    assign s_axis_tready = grant & {N_SRC{slice_ready}};

    assign m_axis_tdata = out_beat[DATA_W-1:0];
    assign m_axis_tlast = out_beat[OFS_LAST];
    assign m_axis_tkeep = KEEP_EN ? out_beat[OFS_KEEP +: KEEP_W] : {KEEP_W{1'b1}};
    assign m_axis_tid   = ID_EN   ? out_beat[OFS_ID   +: ID_W]   : {ID_W{1'b0}};
    assign m_axis_tdest = DEST_EN ? out_beat[OFS_DEST +: DEST_W] : {DEST_W{1'b0}};
    assign m_axis_tuser = USER_EN ? out_beat[OFS_USER +: USER_W] : {USER_W{1'b0}};

    // R2: never two inputs ready together
    a_r2_single_ready: assert property (@(posedge clk) disable iff (rst)
        $onehot0(s_axis_tready));

    // R2: a ready input is always the one the control has granted
    a_r2_ready_granted: assert property (@(posedge clk) disable iff (rst)
        ((s_axis_tready & ~grant) == '0));

endmodule

// File: tb/smux_stream_mux_tb.sv
`timescale 1ns/1ps
module smux_stream_mux_tb;

    localparam int NS = 3, DW = 8, KW = 1, IW = 2, TW = 2, UW = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    // main (framed) instance
    logic          enable = 1'b0;
    logic [1:0]    select = 2'd0;
    logic [NS*DW-1:0] s_data = '0;
    logic [NS*KW-1:0] s_keep = '0;
    logic [NS-1:0] s_valid = '0, s_ready, s_last = '0;
    logic [NS*IW-1:0] s_id = '0;
    logic [NS*TW-1:0] s_dest = '0;
    logic [NS*UW-1:0] s_user = '0;
    logic [DW-1:0] m_data;
    logic [KW-1:0] m_keep;
    logic          m_valid, m_ready = 1'b1, m_last;
    logic [IW-1:0] m_id;
    logic [TW-1:0] m_dest;
    logic [UW-1:0] m_user;

    smux_stream_mux #(.N_SRC(NS), .DATA_W(DW), .ID_W(IW), .DEST_W(TW), .USER_W(UW)) u_dut (
        .clk(clk), .rst(rst), .enable(enable), .select(select),
        .s_axis_tdata(s_data), .s_axis_tkeep(s_keep), .s_axis_tvalid(s_valid),
        .s_axis_tready(s_ready), .s_axis_tlast(s_last), .s_axis_tid(s_id),
        .s_axis_tdest(s_dest), .s_axis_tuser(s_user),
        .m_axis_tdata(m_data), .m_axis_tkeep(m_keep), .m_axis_tvalid(m_valid),
        .m_axis_tready(m_ready), .m_axis_tlast(m_last), .m_axis_tid(m_id),
        .m_axis_tdest(m_dest), .m_axis_tuser(m_user));

    // unframed instance, keep disabled
    logic [1:0]    r_select = 2'd0;
    logic [NS*DW-1:0] r_data = '0;
    logic [NS-1:0] r_valid = '0, r_ready, r_last = '0;
    logic [DW-1:0] rm_data;
    logic [KW-1:0] rm_keep;
    logic          rm_valid, rm_last;
    logic [IW-1:0] rm_id;
    logic [TW-1:0] rm_dest;
    logic [UW-1:0] rm_user;

    smux_stream_mux #(.N_SRC(NS), .DATA_W(DW), .KEEP_EN(1'b0), .ID_W(IW), .DEST_W(TW),
                      .USER_W(UW), .FRAMED(1'b0)) u_dut_raw (
        .clk(clk), .rst(rst), .enable(1'b1), .select(r_select),
        .s_axis_tdata(r_data), .s_axis_tkeep('0), .s_axis_tvalid(r_valid),
        .s_axis_tready(r_ready), .s_axis_tlast(r_last), .s_axis_tid('0),
        .s_axis_tdest('0), .s_axis_tuser('0),
        .m_axis_tdata(rm_data), .m_axis_tkeep(rm_keep), .m_axis_tvalid(rm_valid),
        .m_axis_tready(1'b1), .m_axis_tlast(rm_last), .m_axis_tid(rm_id),
        .m_axis_tdest(rm_dest), .m_axis_tuser(rm_user));

    // scoreboard: {last, user, dest, id, keep, data}
    logic [14:0] exp_q[$];
    int  rx_count = 0;
    bit  bp_mode = 1'b0;
    bit  gap_watch = 1'b0;
    int  gap_end = 0;
    int  gaps = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send_frame(input int src, input int len, input int seq0);
        for (int k = 0; k < len; k++) begin
            logic [5:0] sq;
            bit got;
            sq = 6'(seq0 + k);
            got = 1'b0;
            s_valid[src] = 1'b1;
            s_data[src*DW +: DW] = {2'(src), sq};
            s_keep[src] = sq[0];
            s_id[src*IW +: IW] = 2'(src);
            s_dest[src*TW +: TW] = 2'b11;
            s_user[src] = sq[1];
            s_last[src] = (k == len - 1);
            while (!got) begin
                @(negedge clk);
                if (s_ready[src]) begin
                    // R6: dest disabled -> expect zero at the output
                    exp_q.push_back({s_last[src], sq[1], 2'b00, 2'(src), sq[0], 2'(src), sq});
                    got = 1'b1;
                end
                @(posedge clk); #1;
            end
        end
        s_valid[src] = 1'b0;
        s_last[src]  = 1'b0;
    endtask

    task automatic wait_drain();
        while (exp_q.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
    endtask

    // consumer ready
    initial begin
        forever begin
            @(posedge clk); #1;
            m_ready = bp_mode ? (($urandom % 3) != 0) : 1'b1;
        end
    end

    // monitor
    initial begin
        logic [14:0] prev_beat, cur_beat, e;
        bit prev_stall = 1'b0;
        bit in_frame = 1'b0;
        bit seen = 1'b0;
        logic [1:0] frame_tag = 2'd0;
        forever begin
            @(negedge clk);
            cur_beat = {m_last, m_user, m_dest, m_id, m_keep, m_data};
            if (!rst) begin
                chk($countones(s_ready) <= 1, "R2", "ready count", $countones(s_ready), 1);
                if (prev_stall)
                    chk(m_valid && cur_beat == prev_beat, "R3", "held beat", cur_beat, prev_beat);
                if (gap_watch) begin
                    if (m_valid) seen = 1'b1;
                    else if (seen && rx_count < gap_end) gaps++;
                end else seen = 1'b0;
                if (m_valid && m_ready) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R10", "unexpected beat", cur_beat, 0);
                    end else begin
                        e = exp_q.pop_front();
                        chk(cur_beat == e, "R10", "beat", cur_beat, e);
                    end
                    chk(m_dest == 2'b00, "R6", "dest constant", m_dest, 0);
                    if (in_frame)
                        chk(m_data[7:6] == frame_tag, "R1", "frame source", m_data[7:6], frame_tag);
                    frame_tag = m_data[7:6];
                    in_frame  = !m_last;
                    rx_count++;
                end
                prev_stall = m_valid && !m_ready;
                prev_beat  = cur_beat;
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int base;
        // R8: reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!m_valid, "R8", "m_valid in reset", m_valid, 0);
        chk(s_ready == '0, "R8", "s_ready in reset", s_ready, 0);
        chk(r_ready == '0, "R8", "raw s_ready in reset", r_ready, 0);
        @(posedge clk); #1;
        rst = 1'b0;
        enable = 1'b1;
        select = 2'd0;

        // R10: single frame from input 0
        base = rx_count;
        send_frame(0, 4, 0);
        wait_drain();
        chk(rx_count - base == 4, "R10", "beats of frame", rx_count - base, 4);

        // R1: select moved mid-frame while input 1 already waits
        base = rx_count;
        fork
            send_frame(0, 6, 8);
            send_frame(1, 3, 16);
            begin
                repeat (3) @(posedge clk); #1;
                select = 2'd1;
            end
        join
        wait_drain();
        chk(rx_count - base == 9, "R1", "beats after switch", rx_count - base, 9);

        // R4: chained frames, source change, no idle cycle
        base = rx_count;
        gaps = 0;
        gap_end = base + 7;
        gap_watch = 1'b1;
        fork
            send_frame(1, 3, 24);
            send_frame(2, 4, 32);
            begin
                @(posedge clk); #1;
                select = 2'd2;
            end
        join
        wait_drain();
        gap_watch = 1'b0;
        chk(gaps == 0, "R4", "idle cycles between frames", gaps, 0);
        chk(rx_count - base == 7, "R4", "beats chained", rx_count - base, 7);

        // R3: random backpressure over long frames
        bp_mode = 1'b1;
        base = rx_count;
        send_frame(2, 12, 40);
        select = 2'd0;
        send_frame(0, 9, 52);
        wait_drain();
        bp_mode = 1'b0;
        repeat (2) @(posedge clk); #1;
        chk(rx_count - base == 21, "R3", "beats under backpressure", rx_count - base, 21);

        // R9: out-of-range select
        select = 2'd3;
        repeat (2) @(posedge clk); #1;
        s_valid[0] = 1'b1;
        s_last[0]  = 1'b1;
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk(s_ready == '0, "R9", "ready with select 3", s_ready, 0);
        chk(!m_valid, "R9", "output with select 3", m_valid, 0);
        @(posedge clk); #1;
        s_valid[0] = 1'b0;
        s_last[0]  = 1'b0;
        select = 2'd0;

        // R7: enable low blocks a start, drop inside a frame completes it
        enable = 1'b0;
        base = rx_count;
        fork
            send_frame(0, 5, 60);
            begin
                repeat (5) @(negedge clk);
                chk(s_ready == '0, "R7", "ready while disabled", s_ready, 0);
                chk(rx_count == base, "R7", "beats while disabled", rx_count - base, 0);
                @(posedge clk); #1;
                enable = 1'b1;
                @(negedge clk);
                while (!s_ready[0]) @(negedge clk);
                @(posedge clk); #1;
                enable = 1'b0;
            end
        join
        wait_drain();
        chk(rx_count - base == 5, "R7", "frame finished after enable low", rx_count - base, 5);
        s_valid[1] = 1'b1;
        repeat (4) @(negedge clk);
        chk(s_ready == '0, "R7", "no new frame while disabled", s_ready, 0);
        @(posedge clk); #1;
        s_valid[1] = 1'b0;
        enable = 1'b1;

        // R5 / R6: unframed instance, switch with no tlast on input 0
        r_data[0 +: DW]  = 8'h05;
        r_data[DW +: DW] = 8'h4A;
        r_last = 3'b010;
        r_valid = 3'b011;
        r_select = 2'd0;
        repeat (5) @(negedge clk);
        chk(rm_valid && rm_data == 8'h05, "R5", "static route", rm_data, 8'h05);
        chk(rm_keep == 1'b1, "R6", "keep constant", rm_keep, 1);
        chk(rm_last == 1'b0, "R5", "tlast from input 0", rm_last, 0);
        @(posedge clk); #1;
        r_select = 2'd1;
        repeat (4) @(negedge clk);
        chk(rm_valid && rm_data == 8'h4A, "R5", "mid-frame switch", rm_data, 8'h4A);
        chk(rm_last == 1'b1, "R5", "tlast forwarded", rm_last, 1);
        @(posedge clk); #1;
        r_valid = '0;

        repeat (4) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule